// File: doc/BRIEF.md
# Logarithmic Table Divider

This block gives an approximate quotient of two small unsigned integers without a divider array. Each operand is first reduced to a six-bit mantissa in the range 32..63. The number of right shifts this takes goes into a shared signed exponent: shifts of the dividend add to it, shifts of the divisor subtract from it. The low five bits of each mantissa address a small logarithm ROM. The two four-bit log codes are subtracted. The difference selects an entry of a sixteen-entry exponential ROM. That entry is shifted left by the exponent, which gives a fixed-point quotient with five fractional bits.

The datapath is a three-stage pipeline: normalize, then log lookup and subtract, then exponential lookup and shift. It accepts a new operand pair on every cycle in which `start` is high. Each result leaves exactly three clock edges after its inputs were sampled, with `resultValid` high for one cycle. An operand that is too small, or a quotient whose scale does not fit the output, is reported through `resultError` in the same cycle as the result.

Top module: `logexp_div`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `resultValid`, `resultError` and `quotient` are all zero.
- R2: A pair sampled with `start` high at clock edge k produces `resultValid` high only after edge k+2, and for one cycle. A cycle with `start` low produces no result. Back-to-back starts produce back-to-back results.
- R3: Each operand is shifted right one bit at a time while it is 64 or more. The fraction index is the shifted value minus 32, which is its low five bits. The exponent is the dividend's shift count minus the divisor's shift count.
- R4: Log code for fraction index i is round(22.56 · ln(1 + (i + 0.5)/32)), a value in 0..15. The difference is the dividend code minus the divisor code, always in −15..15.
- R5: The exponential ROM is addressed by the low four bits of the difference in two's complement. Entry k is round(32 · exp(k / 22.56)). When the difference is negative, the exponent is reduced by one.
- R6: With no error, `quotient` equals the ROM entry shifted left by the corrected exponent. The true value is `quotient`/32, and `quotient` is at least 32.
- R7: `resultError` is 1 and `quotient` is 0 when either operand is below 32 (zero included), or when the corrected exponent is below 0 or above 2.
- R8: For every error-free result, `quotient`/32 differs from dividend/divisor by at most one eighth of dividend/divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operands valid this cycle |
| dividend | input | 9 | Numerator, unsigned |
| divisor | input | 9 | Denominator, unsigned |
| quotient | output | 8 | Quotient, 5 fractional bits |
| resultValid | output | 1 | Result present this cycle |
| resultError | output | 1 | Operand or scale out of range |

## Verification
A wrong shift count or a wrong log code changes the quotient of the transaction that used it. That shows at the ports three edges after the bad operand pair, and only for that pair, so the bench compares every result against an arithmetic model in the same cycle. A misaligned valid pipeline shows at once as a result one cycle early or late, or a missing or doubled valid pulse. Idle gaps placed in the stream expose it. A wrong exponent correction on negative differences shows as a quotient off by a factor of two, or as a false error flag, on the first pair whose divisor mantissa has the larger log code.

// File: rtl/logexp_div_pkg.sv
package logexp_div_pkg;

  // Load strobes from control to datapath, one per pipeline stage.
  typedef struct packed {
    logic loadNorm;
    logic loadLog;
    logic loadExp;
  } stageStrobes_t;

  // Four-bit log code of a mantissa fraction index (scale 22.56 per e-fold).
  function automatic logic [3:0] logOfFrac(input logic [4:0] idx);
    logic [3:0] code;
    case (idx)
      5'd0:  code = 4'd0;
      5'd1:  code = 4'd1;
      5'd2:  code = 4'd2;
      5'd3:  code = 4'd2;
      5'd4:  code = 4'd3;
      5'd5:  code = 4'd4;
      5'd6:  code = 4'd4;
      5'd7:  code = 4'd5;
      5'd8:  code = 4'd5;
      5'd9:  code = 4'd6;
      5'd10: code = 4'd6;
      5'd11: code = 4'd7;
      5'd12: code = 4'd7;
      5'd13: code = 4'd8;
      5'd14: code = 4'd8;
      5'd15: code = 4'd9;
      5'd16: code = 4'd9;
      5'd17: code = 4'd10;
      5'd18: code = 4'd10;
      5'd19: code = 4'd11;
      5'd20: code = 4'd11;
      5'd21: code = 4'd12;
      5'd22: code = 4'd12;
      5'd23: code = 4'd12;
      5'd24: code = 4'd13;
      5'd25: code = 4'd13;
      5'd26: code = 4'd14;
      5'd27: code = 4'd14;
      5'd28: code = 4'd14;
      default: code = 4'd15;
    endcase
    return code;
  endfunction

  // Mantissa of 32*exp(k/22.56); entry 16 would be close to 64, so wrapped
  // negative steps read the doubled value.
  function automatic logic [5:0] expOfStep(input logic [3:0] k);
    logic [5:0] m;
    case (k)
      4'd0:  m = 6'd32;
      4'd1:  m = 6'd33;
      4'd2:  m = 6'd35;
      4'd3:  m = 6'd37;
      4'd4:  m = 6'd38;
      4'd5:  m = 6'd40;
      4'd6:  m = 6'd42;
      4'd7:  m = 6'd44;
      4'd8:  m = 6'd46;
      4'd9:  m = 6'd48;
      4'd10: m = 6'd50;
      4'd11: m = 6'd52;
      4'd12: m = 6'd54;
      4'd13: m = 6'd57;
      4'd14: m = 6'd60;
      default: m = 6'd62;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/logexp_div_ctrl.sv
module logexp_div_ctrl
  import logexp_div_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output stageStrobes_t strobes,
  output logic          resultValid
);

  logic normValid;
  logic logValid;
  logic expValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      normValid <= 1'b0;
      logValid  <= 1'b0;
      expValid  <= 1'b0;
    end else begin
      normValid <= start;
      logValid  <= normValid;
      expValid  <= logValid;
    end
  end

  always_comb begin
    strobes.loadNorm = start;
    strobes.loadLog  = normValid;
    strobes.loadExp  = logValid;
  end

  assign resultValid = expValid;

  // R2: with nothing in flight and no new start, no result may appear next cycle
  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
    (!start && !normValid && !logValid) |=> !resultValid);

endmodule

// File: rtl/logexp_div_path.sv
module logexp_div_path
  import logexp_div_pkg::*;
#(
  parameter int OPW    = 9,
  parameter int MAXEXP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  stageStrobes_t     strobes,
  input  logic [OPW-1:0]    dividend,
  input  logic [OPW-1:0]    divisor,
  output logic [MAXEXP+5:0] quotient,
  output logic              resultError
);

  localparam int SHW = OPW - 6;
  localparam int EW  = $clog2(OPW) + 2;
  localparam int QW  = MAXEXP + 6;
  localparam logic signed [EW-1:0] ONE_E = EW'(1);
  localparam logic signed [EW-1:0] TOP_E = EW'(MAXEXP);
  localparam logic signed [5:0]    DMAX  = 6'sd15;
  localparam logic signed [5:0]    DMIN  = -6'sd15;

  function automatic logic [EW-1:0] shiftCount(input logic [OPW-1:0] v);
    logic [OPW-1:0] t;
    logic [EW-1:0]  c;
    t = v;
    c = '0;
    for (int i = 0; i < SHW; i++) begin
      if (t >= OPW'(64)) begin
        t = t >> 1;
        c = c + EW'(1);
      end
    end
    return c;
  endfunction

  // ---------------- stage 1: normalize ----------------
  logic [EW-1:0]  shA, shB;
  logic [OPW-1:0] mantA, mantB;
  logic           lowOperand;

  always_comb begin
    shA        = shiftCount(dividend);
    shB        = shiftCount(divisor);
    mantA      = dividend >> shA;
    mantB      = divisor >> shB;
    lowOperand = (dividend < OPW'(32)) || (divisor < OPW'(32));
  end

  logic [4:0]           fracA1, fracB1;
  logic signed [EW-1:0] expo1;
  logic                 err1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fracA1 <= '0;
      fracB1 <= '0;
      expo1  <= '0;
      err1   <= 1'b0;
    end else if (strobes.loadNorm) begin
      fracA1 <= mantA[4:0];
      fracB1 <= mantB[4:0];
      expo1  <= $signed(shA) - $signed(shB);
      err1   <= lowOperand;
    end
  end

  // ---------------- stage 2: log lookup and subtract ----------------
  logic signed [5:0]    diffNext;
  logic signed [EW-1:0] expoCorr;

  always_comb begin
    diffNext = $signed({2'b00, logOfFrac(fracA1)}) - $signed({2'b00, logOfFrac(fracB1)});
    expoCorr = diffNext[5] ? (expo1 - ONE_E) : expo1;
  end

  logic signed [5:0]    diff2;
  logic signed [EW-1:0] expo2;
  logic                 err2;

  always_ff @(posedge clk) begin
    if (rst) begin
      diff2 <= '0;
      expo2 <= '0;
      err2  <= 1'b0;
    end else if (strobes.loadLog) begin
      diff2 <= diffNext;
      expo2 <= expoCorr;
      err2  <= err1;
    end
  end

  // R4: log codes stay within four bits, so the difference spans -15..15
  assert_diff_span_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadExp |-> (diff2 >= DMIN && diff2 <= DMAX));

  // ---------------- stage 3: exp lookup and denormalize ----------------
  logic          scaleBad;
  logic [QW-1:0] scaled;

  always_comb begin
    scaleBad = err2 || (expo2 < 0) || (expo2 > TOP_E);
    scaled   = {{(QW-6){1'b0}}, expOfStep(diff2[3:0])} << $unsigned(expo2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient    <= '0;
      resultError <= 1'b0;
    end else if (strobes.loadExp) begin
      quotient    <= scaleBad ? '0 : scaled;
      resultError <= scaleBad;
    end
  end

endmodule

// File: rtl/logexp_div.sv
module logexp_div
  import logexp_div_pkg::*;
#(
  parameter int OPW    = 9,
  parameter int MAXEXP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OPW-1:0]    dividend,
  input  logic [OPW-1:0]    divisor,
  output logic [MAXEXP+5:0] quotient,
  output logic              resultValid,
  output logic              resultError
);

  stageStrobes_t strobes;

  logexp_div_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .strobes     (strobes),
    .resultValid (resultValid)
  );

  logexp_div_path #(
    .OPW    (OPW),
    .MAXEXP (MAXEXP)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .resultError (resultError)
  );

  // R7: a flagged result carries a zero quotient
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (resultValid && resultError) |-> (quotient == '0));

  // R6: a clean result is at least 1.0, since the smallest table entry is 32
  assert_quot_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (resultValid && !resultError) |-> (quotient >= (MAXEXP+6)'(32)));

endmodule

// File: tb/sim_logexp_div.sv
module sim_logexp_div;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [8:0] dividend = '0;
  logic [8:0] divisor = '0;
  logic [7:0] quotient;
  logic       resultValid;
  logic       resultError;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int pv[3];
  int pq[3];
  int pe[3];
  int pn[3];
  int pa[3];
  int pb[3];

  always #2 clk = ~clk;

  logexp_div u0 (
    .clk(clk), .rst(rst), .start(start),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .resultValid(resultValid), .resultError(resultError)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Arithmetic model of the requirements R3..R7
  function automatic void model(input int a, input int b, output int q,
                                output bit err, output bit neg);
    int sa, sb, ma, mb, la, lb, d, e, k, ent;
    sa = 0; sb = 0; ma = a; mb = b;
    q = 0; err = 0; neg = 0;
    if (a < 32 || b < 32) begin
      err = 1;
      return;
    end
    while (ma >= 64) begin ma = ma >> 1; sa++; end
    while (mb >= 64) begin mb = mb >> 1; sb++; end
    la = $rtoi($floor(22.56 * $ln(1.0 + ((ma - 32) + 0.5) / 32.0) + 0.5));
    lb = $rtoi($floor(22.56 * $ln(1.0 + ((mb - 32) + 0.5) / 32.0) + 0.5));
    d = la - lb;
    e = sa - sb;
    k = d;
    if (d < 0) begin
      k = d + 16;
      e = e - 1;
      neg = 1;
    end
    ent = $rtoi($floor(32.0 * $exp(k / 22.56) + 0.5));
    if (e < 0 || e > 2) begin
      err = 1;
      return;
    end
    q = ent << e;
  endfunction

  task automatic runOne(input int a, input int b, input int expQ, input bit expE,
                        input string tag);
    @(negedge clk);
    start = 1'b1; dividend = 9'(a); divisor = 9'(b);
    @(negedge clk);
    start = 1'b0;
    chk(resultValid == 1'b0, "R2 early after 1 edge", int'(resultValid), 0);
    @(negedge clk);
    chk(resultValid == 1'b0, "R2 early after 2 edges", int'(resultValid), 0);
    @(negedge clk);
    chk(resultValid == 1'b1, "R2 valid after 3 edges", int'(resultValid), 1);
    chk(resultError == expE, {tag, " error flag"}, int'(resultError), int'(expE));
    chk(int'(quotient) == expQ, {tag, " quotient"}, int'(quotient), expQ);
    @(negedge clk);
    chk(resultValid == 1'b0, "R2 single pulse", int'(resultValid), 0);
  endtask

  // One streaming cycle: check the pair driven three cycles ago, then drive.
  task automatic step(input bit go, input int a, input int b);
    int q;
    bit err;
    bit neg;
    string tag;
    real ratio;
    real got;
    @(negedge clk);
    chk(int'(resultValid) == pv[2], "R2 stream valid", int'(resultValid), pv[2]);
    if (pv[2] != 0) begin
      tag = (pe[2] != 0) ? "R7" : ((pn[2] != 0) ? "R5" : "R6");
      chk(int'(resultError) == pe[2], {tag, " error flag"}, int'(resultError), pe[2]);
      if (int'(quotient) != pq[2])
        $display("  pair %0d/%0d", pa[2], pb[2]);
      chk(int'(quotient) == pq[2], {tag, " quotient"}, int'(quotient), pq[2]);
      if (pe[2] == 0) begin
        ratio = real'(pa[2]) / real'(pb[2]);
        got = real'(quotient) / 32.0;
        chk((got - ratio <= ratio / 8.0) && (ratio - got <= ratio / 8.0),
            "R8 accuracy (x1000)", $rtoi(got * 1000.0), $rtoi(ratio * 1000.0));
      end
    end
    for (int i = 2; i > 0; i--) begin
      pv[i] = pv[i-1]; pq[i] = pq[i-1]; pe[i] = pe[i-1];
      pn[i] = pn[i-1]; pa[i] = pa[i-1]; pb[i] = pb[i-1];
    end
    start = go; dividend = 9'(a); divisor = 9'(b);
    model(a, b, q, err, neg);
    pv[0] = int'(go); pq[0] = q; pe[0] = int'(err); pn[0] = int'(neg);
    pa[0] = a; pb[0] = b;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      pv[i] = 0; pq[i] = 0; pe[i] = 0; pn[i] = 0; pa[i] = 0; pb[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(resultValid == 1'b0, "R1 valid in reset", int'(resultValid), 0);
    chk(resultError == 1'b0, "R1 error in reset", int'(resultError), 0);
    chk(quotient == 8'd0, "R1 quotient in reset", int'(quotient), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(resultValid == 1'b0, "R1 valid after reset", int'(resultValid), 0);

    // Directed cases with hand-worked results
    runOne(64, 32, 64, 1'b0, "R3 one dividend shift gives 2.0");
    runOne(63, 32, 62, 1'b0, "R4 top log code minus bottom");
    runOne(100, 40, 80, 1'b0, "R6 shift by exponent 1 gives 2.5");
    runOne(70, 50, 46, 1'b0, "R5 negative difference wraps and drops exponent");
    runOne(33, 63, 0, 1'b1, "R7 exponent below zero");
    runOne(511, 32, 0, 1'b1, "R7 exponent above two");
    runOne(20, 10, 0, 1'b1, "R7 operand below 32");
    runOne(200, 0, 0, 1'b1, "R7 zero divisor");

    // Streaming sweep with periodic idle cycles
    for (int a = 33; a <= 511; a += 2) begin
      for (int b = 24; b <= 511; b++) begin
        if (b % 64 == 0) step(1'b0, 0, 0);
        step(1'b1, a, b);
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule